// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block keeps the cycle time of a node on an isochronous serial bus. A 32-bit timer holds three fields: a seconds count, a cycle count and a cycle offset. It is clocked by the 49.152 MHz clock that the physical layer supplies. The offset moves once every two clocks and completes 3072 steps per cycle, so the cycle count advances at 8 kHz. The seconds count advances once per 8000 cycles.

Cycle boundaries come from one of two sources, chosen by a mode bit. The first is the internal offset wrap. The second is the rising edge of an external cycle-input pin. The cycle-output pin pulses once at every boundary. A node acting as cycle master raises a request to send a cycle-start packet at each boundary. The request is held until the packet logic acknowledges it. A boundary that finds the request still pending sets a sticky missed-cycle flag. A node that is not master does not raise requests. Instead, it loads the timer with the value carried in each received cycle-start packet.

Top module: `bus_cycle_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `timer_value`, `cycle_out`, `cs_req` and `cs_missed` to 0.
- R2: The fields of `timer_value` are seconds in [31:25], cycle count in [24:12] and offset in [11:0]. With `cfg_src_pin`=0, the offset steps once every second clock. The first step comes at the second edge after reset or after a load. A step from 3071 goes to 0 and adds one to the cycle count.
- R3: A cycle-count increment from 7999 goes to 0 and adds one to the seconds. An increment of seconds from 127 goes to 0.
- R4: `cycle_out` is high for exactly one clock at each cycle boundary. That clock is the first one in which `timer_value` shows the new cycle with offset 0.
- R5: With `cfg_master`=1, each boundary sets `cs_req`. `cs_req` then stays high until a clock with `cs_ack`=1 and no boundary clears it.
- R6: `cs_missed` is set by a boundary with `cfg_master`=1 that finds `cs_req` already high and `cs_ack` low. It stays set until reset.
- R7: With `cfg_src_pin`=1, boundaries come only at a rising edge of `cycle_in`: a clock where it is sampled high after being sampled low. The boundary sets the offset to 0 and adds one to the cycle count. Between edges the offset steps as in R2 but holds at 3071 instead of wrapping.
- R8: With `cfg_master`=0 and `load_valid`=1, the next `timer_value` equals `load_value` and the prescaler restarts. A boundary that would fall in that clock is dropped.
- R9: With `cfg_master`=1, `load_valid` has no effect on the timer.
- R10: With `cfg_master`=0, boundaries still pulse `cycle_out`, but `cs_req` is never set.
- R11: A loaded offset above 3071 is treated as 3071, and a loaded cycle count above 7999 is treated as 7999. The next step or increment wraps them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 49.152 MHz clock from the physical layer |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1: node is cycle master; 0: node follows received packets |
| cfg_src_pin | input | 1 | 1: boundaries from `cycle_in`; 0: from the internal offset wrap |
| cycle_in | input | 1 | External cycle-input pin, synchronous to `clk` |
| load_valid | input | 1 | A received cycle-start packet carries `load_value` this clock |
| load_value | input | 32 | Timer value from the received packet |
| cs_ack | input | 1 | Packet logic has taken the pending cycle-start request |
| cycle_out | output | 1 | One-clock pulse at each cycle boundary |
| cs_req | output | 1 | Cycle-start request, pending until acknowledged |
| cs_missed | output | 1 | Sticky flag: a request was raised while one was pending |
| timer_value | output | 32 | Current timer {seconds, cycle count, offset} |

## Verification
Every result is due one clock after the edge that samples its cause. A load, a `cycle_in` rising edge, an acknowledge or an offset wrap is visible in `timer_value`, `cycle_out`, `cs_req` and `cs_missed` from that edge on. An offset step follows the two-clock prescaler that a load or reset restarts. The bench drives inputs on the falling edge and advances its own model of the requirements on each rising edge. It compares all four outputs at the next falling edge, so every result is checked in exactly the clock it is due. Directed stretches preload values close to a wrap, so that the seconds and cycle carries, the saturation and the missed flag come within tens of clocks. Random stretches then mix modes, loads, pin edges and acknowledges.

// File: rtl/cyc_timer_pkg.sv
// Shared constants and types for the cycle timer.
// Assumes the default limits: 3072 offset steps, 8000 cycles, 128 seconds.
package cyc_timer_pkg;
    localparam int DEF_OFS_LIMIT = 3072;
    localparam int DEF_CYC_LIMIT = 8000;
    localparam int DEF_SEC_LIMIT = 128;
    localparam int DEF_PRESCALE  = 2;

    typedef enum logic {
        SRC_DIVIDER = 1'b0,
        SRC_PIN     = 1'b1
    } cyc_src_e;
endpackage

// File: rtl/ct_prescale.sv
// Clock prescaler: produces one advance pulse every DIV clocks.
// Assumes restart is a single-clock pulse; after a restart the count is 0.
module ct_prescale #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic advance
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign advance = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            assign advance = (cnt == CW'(DIV - 1));

            // Count clocks and return to zero on an advance or a restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart || advance)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/ct_offset.sv
// Cycle offset counter.
// Assumes: a load has priority over everything else. In divider mode the
// offset wraps at LIMIT-1 and flags a boundary. In pin mode the offset
// saturates at LIMIT-1, and only ext_rise flags a boundary.
module ct_offset #(
    parameter int LIMIT = 3072,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         pin_mode,
    input  logic         ext_rise,
    input  logic         load,
    input  logic [W-1:0] load_ofs,
    output logic [W-1:0] ofs,
    output logic         boundary
);
    logic at_last;

    // Detect the last offset step and decide whether this clock ends a cycle.
    always_comb begin
        at_last  = (ofs >= W'(LIMIT - 1));
        boundary = !load && (pin_mode ? ext_rise : (advance && at_last));
    end

    // Update the offset from load, pin edge or prescaled advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs <= '0;
        else if (load)
            ofs <= load_ofs;
        else if (pin_mode) begin
            if (ext_rise)
                ofs <= '0;
            else if (advance && !at_last)
                ofs <= ofs + 1'b1;
        end else if (advance)
            ofs <= at_last ? '0 : ofs + 1'b1;
    end
endmodule

// File: rtl/ct_cycle_sec.sv
// Cycle count and seconds count.
// Assumes boundary is never high in a clock with load. The cycle count wraps
// at CYC_LIMIT-1 into seconds; seconds wrap at SEC_LIMIT-1.
module ct_cycle_sec #(
    parameter int CYC_LIMIT = 8000,
    parameter int CYC_W     = 13,
    parameter int SEC_LIMIT = 128,
    parameter int SEC_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             load,
    input  logic [CYC_W-1:0] load_cyc,
    input  logic [SEC_W-1:0] load_sec,
    output logic [CYC_W-1:0] cyc,
    output logic [SEC_W-1:0] sec
);
    logic             cyc_carry;
    logic [SEC_W-1:0] sec_next;

    assign cyc_carry = boundary && (cyc >= CYC_W'(CYC_LIMIT - 1));

    generate
        if (SEC_LIMIT == (1 << SEC_W)) begin : g_sec_pow2
            assign sec_next = sec + 1'b1;
        end else begin : g_sec_cmp
            assign sec_next = (sec >= SEC_W'(SEC_LIMIT - 1)) ? '0 : sec + 1'b1;
        end
    endgenerate

    // Advance the cycle count at each boundary, carrying into seconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
            sec <= '0;
        end else if (load) begin
            cyc <= load_cyc;
            sec <= load_sec;
        end else if (cyc_carry) begin
            cyc <= '0;
            sec <= sec_next;
        end else if (boundary)
            cyc <= cyc + 1'b1;
    end
endmodule

// File: rtl/ct_request.sv
// Cycle output pulse, cycle-start request and the missed-cycle flag.
// Assumes boundary is a single-clock strobe. A boundary in master mode
// outranks an acknowledge in the same clock.
module ct_request (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic master,
    input  logic ack,
    output logic cycle_out,
    output logic req,
    output logic missed
);
    // Register the boundary pulse, the pending request and the sticky miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_out <= 1'b0;
            req       <= 1'b0;
            missed    <= 1'b0;
        end else begin
            cycle_out <= boundary;
            if (master && boundary) begin
                req <= 1'b1;
                if (req && !ack)
                    missed <= 1'b1;
            end else if (ack)
                req <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_cycle_timer.sv
// Isochronous cycle timer: {seconds, cycle count, offset}, driven from the
// physical layer clock or the external cycle pin. It requests cycle-start
// packets as master and follows received timer values as slave.
// Assumes cycle_in is already synchronous to clk.
module bus_cycle_timer
    import cyc_timer_pkg::*;
#(
    parameter int OFS_LIMIT = DEF_OFS_LIMIT,
    parameter int CYC_LIMIT = DEF_CYC_LIMIT,
    parameter int SEC_LIMIT = DEF_SEC_LIMIT,
    parameter int PRESCALE  = DEF_PRESCALE,
    localparam int OFS_W    = $clog2(OFS_LIMIT),
    localparam int CYC_W    = $clog2(CYC_LIMIT),
    localparam int SEC_W    = $clog2(SEC_LIMIT),
    localparam int TIMER_W  = SEC_W + CYC_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic               cfg_src_pin,
    input  logic               cycle_in,
    input  logic               load_valid,
    input  logic [TIMER_W-1:0] load_value,
    input  logic               cs_ack,
    output logic               cycle_out,
    output logic               cs_req,
    output logic               cs_missed,
    output logic [TIMER_W-1:0] timer_value
);
    cyc_src_e         src;
    logic             cin_q;
    logic             ext_rise;
    logic             load;
    logic             advance;
    logic             boundary;
    logic [OFS_W-1:0] ofs;
    logic [CYC_W-1:0] cyc;
    logic [SEC_W-1:0] sec;

    // Select the boundary source and qualify a load by the mode.
    always_comb begin
        src      = cfg_src_pin ? SRC_PIN : SRC_DIVIDER;
        load     = load_valid && !cfg_master;
        ext_rise = cycle_in && !cin_q;
    end

    // Keep the previous sample of the cycle pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cin_q <= 1'b0;
        else
            cin_q <= cycle_in;
    end

    ct_prescale #(.DIV(PRESCALE)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .advance (advance)
    );

    ct_offset #(.LIMIT(OFS_LIMIT), .W(OFS_W)) u_offset (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .pin_mode (src == SRC_PIN),
        .ext_rise (ext_rise),
        .load     (load),
        .load_ofs (load_value[OFS_W-1:0]),
        .ofs      (ofs),
        .boundary (boundary)
    );

    ct_cycle_sec #(
        .CYC_LIMIT (CYC_LIMIT),
        .CYC_W     (CYC_W),
        .SEC_LIMIT (SEC_LIMIT),
        .SEC_W     (SEC_W)
    ) u_cycle_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .load     (load),
        .load_cyc (load_value[OFS_W +: CYC_W]),
        .load_sec (load_value[OFS_W + CYC_W +: SEC_W]),
        .cyc      (cyc),
        .sec      (sec)
    );

    ct_request u_request (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .master    (cfg_master),
        .ack       (cs_ack),
        .cycle_out (cycle_out),
        .req       (cs_req),
        .missed    (cs_missed)
    );

    assign timer_value = {sec, cyc, ofs};
endmodule

// File: rtl/ct_timer_checker.sv
// Port-level properties of the cycle timer, bound to every instance.
module ct_timer_checker #(
    parameter int OFS_W   = 12,
    parameter int TIMER_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_master,
    input logic               load_valid,
    input logic [TIMER_W-1:0] load_value,
    input logic               cs_ack,
    input logic               cycle_out,
    input logic               cs_req,
    input logic               cs_missed,
    input logic [TIMER_W-1:0] timer_value
);
    // R4: the pulse lasts one clock
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_out |=> !cycle_out);

    // R4: the pulse coincides with offset 0
    a_r4_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_out |-> (timer_value[OFS_W-1:0] == '0));

    // R5: a request only drops after an acknowledge
    a_r5_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_req) |-> $past(cs_ack));

    // R6: the missed flag is sticky
    a_r6_missed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cs_missed |=> cs_missed);

    // R8: a slave load appears on the next clock
    a_r8_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !cfg_master) |=> (timer_value == $past(load_value)));

    // R10: a request only rises in master mode
    a_r10_req_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_req) |-> $past(cfg_master));
endmodule

bind bus_cycle_timer ct_timer_checker #(.OFS_W(OFS_W), .TIMER_W(TIMER_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_master  (cfg_master),
    .load_valid  (load_valid),
    .load_value  (load_value),
    .cs_ack      (cs_ack),
    .cycle_out   (cycle_out),
    .cs_req      (cs_req),
    .cs_missed   (cs_missed),
    .timer_value (timer_value)
);

// File: tb/test_bus_cycle_timer.sv
module test_bus_cycle_timer;
    localparam int CLK_PERIOD = 10;
    localparam int OFS_N = 3072;
    localparam int CYC_N = 8000;
    localparam int SEC_N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b0;
    logic        cfg_src_pin = 1'b0;
    logic        cycle_in = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_value = '0;
    logic        cs_ack = 1'b0;
    logic        cycle_out;
    logic        cs_req;
    logic        cs_missed;
    logic [31:0] timer_value;

    int    total = 0;
    int    bad = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_ofs, m_cyc, m_sec;
    bit m_cinq, m_cout, m_req, m_miss;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_cycle_timer i_bus_cycle_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_master  (cfg_master),
        .cfg_src_pin (cfg_src_pin),
        .cycle_in    (cycle_in),
        .load_valid  (load_valid),
        .load_value  (load_value),
        .cs_ack      (cs_ack),
        .cycle_out   (cycle_out),
        .cs_req      (cs_req),
        .cs_missed   (cs_missed),
        .timer_value (timer_value)
    );

    function automatic logic [31:0] pack_time(int s, int c, int o);
        logic [6:0]  s7  = 7'(s);
        logic [12:0] c13 = 13'(c);
        logic [11:0] o12 = 12'(o);
        return {s7, c13, o12};
    endfunction

    // Model: one clock of the requirements, applied at each rising edge.
    always @(posedge clk) begin
        bit rise, ld, adv, bnd;
        if (!rst_n) begin
            m_cnt = 0; m_ofs = 0; m_cyc = 0; m_sec = 0;
            m_cinq = 0; m_cout = 0; m_req = 0; m_miss = 0;
        end else begin
            rise   = cycle_in && !m_cinq;
            m_cinq = cycle_in;
            ld     = load_valid && !cfg_master;
            adv    = (m_cnt == 1);
            m_cnt  = (ld || adv) ? 0 : m_cnt + 1;
            bnd    = 0;
            if (ld) begin
                m_ofs = int'(load_value[11:0]);
                m_cyc = int'(load_value[24:12]);
                m_sec = int'(load_value[31:25]);
            end else if (cfg_src_pin) begin
                if (rise) begin
                    m_ofs = 0; bnd = 1;
                end else if (adv && m_ofs < OFS_N - 1)
                    m_ofs++;
            end else if (adv) begin
                if (m_ofs >= OFS_N - 1) begin
                    m_ofs = 0; bnd = 1;
                end else
                    m_ofs++;
            end
            if (bnd) begin
                if (m_cyc >= CYC_N - 1) begin
                    m_cyc = 0;
                    m_sec = (m_sec >= SEC_N - 1) ? 0 : m_sec + 1;
                end else
                    m_cyc++;
            end
            m_cout = bnd;
            if (cfg_master && bnd) begin
                if (m_req && !cs_ack) m_miss = 1;
                m_req = 1;
            end else if (cs_ack)
                m_req = 0;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(cur_req, "timer", timer_value, pack_time(m_sec, m_cyc, m_ofs));
            check(cur_req, "cycle_out", 32'(cycle_out), 32'(m_cout));
            check(cur_req, "cs_req", 32'(cs_req), 32'(m_req));
            check(cur_req, "cs_missed", 32'(cs_missed), 32'(m_miss));
        end
    end

    task automatic clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(int s, int c, int o);
        @(negedge clk);
        load_valid = 1'b1;
        load_value = pack_time(s, c, o);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic pin_pulse(int hi, int lo);
        cycle_in = 1'b1; clocks(hi);
        cycle_in = 1'b0; clocks(lo);
    endtask

    initial begin
        void'($urandom(32'd1394));
        // R1: reset state
        clocks(3);
        chk_en = 1'b1;
        cur_req = "R1";
        clocks(2);
        rst_n = 1'b1;

        // R2: master, divider mode, first offset wrap into the cycle count
        cur_req = "R2";
        cfg_master = 1'b1;
        for (int i = 0; i < 6300; i++) begin
            @(negedge clk);
            cs_ack = ($urandom % 8 == 0);
            // R4: pulse seen together with offset 0
            if (cycle_out) check("R4", "offset at pulse", 32'(timer_value[11:0]), 32'd0);
        end
        cs_ack = 1'b0;

        // R3: seconds carry and seconds wrap
        cur_req = "R3";
        cfg_master = 1'b0;
        do_load(127, 7999, 3068);
        clocks(20);
        do_load(40, 7999, 3070);
        clocks(10);

        // R5: request held until acknowledged
        cur_req = "R5";
        do_load(3, 10, 3066);
        cfg_master = 1'b1;
        clocks(20);
        cs_ack = 1'b1; clocks(1); cs_ack = 1'b0;
        clocks(5);

        // R7: pin mode, saturation then edge boundaries
        cur_req = "R7";
        cfg_master = 1'b0;
        cfg_src_pin = 1'b1;
        do_load(1, 5, 3060);
        clocks(40);
        pin_pulse(3, 4);
        pin_pulse(1, 1);
        pin_pulse(5, 2);

        // R6: boundaries while a request is pending
        cur_req = "R6";
        cfg_master = 1'b1;
        pin_pulse(1, 3);
        pin_pulse(1, 3);
        cs_ack = 1'b1; clocks(2); cs_ack = 1'b0;
        pin_pulse(2, 2);
        clocks(4);

        // R9: loads ignored in master mode
        cur_req = "R9";
        cfg_src_pin = 1'b0;
        for (int i = 0; i < 5; i++) begin
            do_load(int'($urandom % 128), int'($urandom % 8000), int'($urandom % 3072));
            clocks(3);
        end

        // R8: slave loads, including back to back and on a wrap clock
        cur_req = "R8";
        cfg_master = 1'b0;
        do_load(9, 99, 3070);
        clocks(1);
        do_load(11, 7998, 3071);
        clocks(1);
        do_load(20, 200, 2000);
        do_load(21, 201, 2001);
        clocks(6);

        // R10: slave boundaries pulse but never request
        cur_req = "R10";
        cs_ack = 1'b1; clocks(1); cs_ack = 1'b0;
        do_load(0, 7999, 3069);
        clocks(12);

        // R11: out-of-range loaded fields wrap on the next step
        cur_req = "R11";
        do_load(5, 8191, 4095);
        clocks(8);
        do_load(127, 8100, 3500);
        clocks(8);

        // Random mix across all modes
        cur_req = "R2";
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if ($urandom % 1500 == 0) cfg_master = ~cfg_master;
            if ($urandom % 2500 == 0) cfg_src_pin = ~cfg_src_pin;
            cs_ack = ($urandom % 6 == 0);
            if ($urandom % 3 == 0) cycle_in = ~cycle_in;
            load_valid = ($urandom % 400 == 0);
            load_value = $urandom;
        end
        load_valid = 1'b0;
        clocks(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule